// File: doc/BRIEF.md
# Row-Scanning Keypad Matrix Encoder

This block drives an 8 x 8 key matrix and turns a single pressed key into a 6-bit code for a host. A rotating pattern pulls exactly one row low at a time. The column lines are pulled up at the pads and read back through a two-stage synchronizer. While every synchronized column reads high, the row pattern keeps moving. As soon as a column reads low on the current row, the rotation stops on that row, and the row and column positions are combined into a key code.

A column change takes two clock cycles to pass the synchronizer. For that reason the block waits on each newly driven row until the columns it reads belong to that row, and only then decides whether to move on. This wait is the settle window. Of the 64 code values, all ones is kept to mean "no key". A valid flag tells the host when the code names a real key. The host watches the code and the flag; debounce and multi-key rollover are left to it.

Top module: `keypad_scan_encoder`

## Requirements
- R1: After reset, row_out is 8'hFE (only row 0 low), key_code is 6'h3F and key_valid is 0.
- R2: Exactly one bit of row_out is 0 at every clock cycle.
- R3: With all columns high, the low row moves from row i to row i+1 (row 7 wraps to row 0). Each row is held for exactly SYNC_STAGES+1 = 3 clock cycles.
- R4: While key_valid is 1, row_out does not change.
- R5: With one key pressed at row r, column c (not both 7), key_valid becomes 1 and key_code equals r*8+c. The row index sits in bits 5:3 and the column index in bits 2:0. The row named in the code is the one driven low.
- R6: Whenever key_valid is 0, key_code is 6'h3F.
- R7: A press at row 7, column 7 stops the scan on row 7 (row_out = 8'h7F) but is reported as no key: key_valid 0 and key_code 6'h3F. key_valid is never 1 together with code 6'h3F.
- R8: When several columns read low on the active row, the code carries the lowest-numbered low column.
- R9: After the key is released, row_out advances within 3 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| col_in | input | 8 | Pulled-up column lines, low when a key on the driven row is pressed |
| row_out | output | 8 | Row drive, one bit low at a time |
| key_code | output | 6 | {row index, column index}, 6'h3F when no key |
| key_valid | output | 1 | High while key_code names a pressed key |

## Verification
Each of the 64 matrix positions is pressed on its own in turn, and the expected code is computed as r*8+c. This separates mistakes in the row encoding from mistakes in the column encoding and in field order. It also shows whether the scan really stops on the pressed row. The corner position (7,7) is checked separately: the scan must stop there while the output still reads as no key. A two-key press on one row checks the lowest-column choice. Idle stretches check the rotation order, the 3-cycle dwell and the reserved code, and release checks that scanning resumes promptly.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  parameter int unsigned KP_ROWS = 8;
  parameter int unsigned KP_COLS = 8;
  parameter int unsigned KP_SYNC = 2;
endpackage

// File: rtl/kpd_col_sync.sv
module kpd_col_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/kpd_row_rotator.sv
module kpd_row_rotator #(
  parameter int unsigned ROWS   = 8,
  parameter int unsigned SETTLE = 2,
  localparam int unsigned CNT_W = $clog2(SETTLE + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cols_idle,
  output logic [ROWS-1:0] row_drv,
  output logic            settled
);
  logic [ROWS-1:0]  row_q, row_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             adv;

  assign settled = (cnt_q == '0);
  assign adv     = settled && cols_idle;

  always_comb begin
    row_nxt = row_q;
    cnt_nxt = cnt_q;
    if (adv) begin
      row_nxt = {row_q[ROWS-2:0], row_q[ROWS-1]};
      cnt_nxt = CNT_W'(SETTLE);
    end else if (!settled) begin
      cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= {{(ROWS-1){1'b1}}, 1'b0};
      cnt_q <= CNT_W'(SETTLE);
    end else begin
      row_q <= row_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign row_drv = row_q;
endmodule

// File: rtl/kpd_zero_index.sv
module kpd_zero_index #(
  parameter int unsigned W  = 8,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          hit
);
  always_comb begin
    idx = '1;
    hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!vec[i]) begin
        idx = IW'(i);
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/keypad_scan_encoder.sv
module keypad_scan_encoder #(
  parameter int unsigned ROWS        = kpd_pkg::KP_ROWS,
  parameter int unsigned COLS        = kpd_pkg::KP_COLS,
  parameter int unsigned SYNC_STAGES = kpd_pkg::KP_SYNC,
  localparam int unsigned RIW    = $clog2(ROWS),
  localparam int unsigned CIW    = $clog2(COLS),
  localparam int unsigned CODE_W = RIW + CIW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COLS-1:0]   col_in,
  output logic [ROWS-1:0]   row_out,
  output logic [CODE_W-1:0] key_code,
  output logic              key_valid
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [COLS-1:0] col_s;
  logic            cols_idle;
  logic            settled;
  logic [RIW-1:0]  row_idx;
  logic [CIW-1:0]  col_idx;
  logic            row_hit, col_hit;
  logic [CODE_W-1:0] raw_code;
  logic            key_hit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  kpd_col_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(col_in), .q(col_s)
  );

  assign cols_idle = &col_s;

  kpd_row_rotator #(.ROWS(ROWS), .SETTLE(SYNC_STAGES)) u_rot (
    .clk(clk), .rst_n(rst_int_n), .cols_idle(cols_idle),
    .row_drv(row_out), .settled(settled)
  );

  kpd_zero_index #(.W(ROWS)) u_row_enc (.vec(row_out), .idx(row_idx), .hit(row_hit));
  kpd_zero_index #(.W(COLS)) u_col_enc (.vec(col_s),   .idx(col_idx), .hit(col_hit));

  assign raw_code  = {row_idx, col_idx};
  assign key_hit   = settled && row_hit && col_hit && (raw_code != '1);
  assign key_valid = key_hit;
  assign key_code  = key_hit ? raw_code : '1;
endmodule

// File: rtl/keypad_scan_encoder_chk.sv
module keypad_scan_encoder_chk #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 8,
  localparam int unsigned RIW    = $clog2(ROWS),
  localparam int unsigned CIW    = $clog2(COLS),
  localparam int unsigned CODE_W = RIW + CIW
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ROWS-1:0]   row_out,
  input logic [CODE_W-1:0] key_code,
  input logic              key_valid
);
  logic [ROWS-1:0] row_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_prev <= {{(ROWS-1){1'b1}}, 1'b0};
    else        row_prev <= row_out;
  end

  assert_one_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~row_out) == 1);

  assert_step_next_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (row_out != row_prev) |-> (row_out == {row_prev[ROWS-2:0], row_prev[ROWS-1]}));

  assert_hold_on_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> $stable(row_out));

  assert_code_row_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> !row_out[key_code[CODE_W-1 -: RIW]]);

  assert_idle_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> (key_code == '1));

  assert_reserved_never_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (key_code != '1));
endmodule

bind keypad_scan_encoder keypad_scan_encoder_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_out(row_out), .key_code(key_code), .key_valid(key_valid)
);

// File: tb/keypad_scan_encoder_test.sv
module keypad_scan_encoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] col_in;
  logic [7:0] row_out;
  logic [5:0] key_code;
  logic       key_valid;

  logic       press = 1'b0, press2 = 1'b0;
  logic [2:0] pr = '0, pc = '0, pc2 = '0;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  keypad_scan_encoder uut (
    .clk(clk), .rst_n(rst_n), .col_in(col_in),
    .row_out(row_out), .key_code(key_code), .key_valid(key_valid)
  );

  // matrix model: a pressed key shorts its column to its row
  always_comb begin
    col_in = '1;
    if (press  && !row_out[pr]) col_in[pc]  = 1'b0;
    if (press2 && !row_out[pr]) col_in[pc2] = 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic wait_valid(input int limit);
    for (int i = 0; i < limit && !key_valid; i++) @(negedge clk);
  endtask

  task automatic release_and_resume();
    logic [7:0] held;
    int k;
    held  = row_out;
    press = 1'b0; press2 = 1'b0;
    k = 0;
    while (row_out == held && k < 4) begin @(negedge clk); k++; end
    check(row_out != held && k <= 3, "R9", k, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int run, changes;
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(row_out == 8'hFE, "R1 row", row_out, 8'hFE);
    check(key_code == 6'h3F && !key_valid, "R1 code", {key_valid, key_code}, 6'h3F);

    // R3 rotation and dwell, R6 idle code
    prev = row_out; run = 1; changes = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(key_code == 6'h3F && !key_valid, "R6", {key_valid, key_code}, 6'h3F);
      if (row_out != prev) begin
        check(row_out == {prev[6:0], prev[7]}, "R3 order", row_out, {prev[6:0], prev[7]});
        if (changes > 0) check(run == 3, "R3 dwell", run, 3);
        changes++; run = 1; prev = row_out;
      end else run++;
    end
    check(changes >= 12, "R3 moves", changes, 12);

    // R5/R4/R7 every key position alone
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) begin
        pr = 3'(r); pc = 3'(c); press = 1'b1;
        if (r == 7 && c == 7) begin
          repeat (40) @(negedge clk);
          check(row_out == 8'h7F, "R7 halt", row_out, 8'h7F);
          check(!key_valid && key_code == 6'h3F, "R7 code", {key_valid, key_code}, 6'h3F);
        end else begin
          wait_valid(40);
          check(key_valid && key_code == 6'(r * 8 + c), "R5", {key_valid, key_code}, 64 + r * 8 + c);
          check(row_out == ~(8'h01 << r), "R5 row", row_out, ~(8'h01 << r));
          prev = row_out;
          repeat (5) @(negedge clk);
          check(row_out == prev && key_valid, "R4", row_out, prev);
        end
        release_and_resume();
      end
    end

    // R8 two keys on one row
    pr = 3'd3; pc = 3'd5; pc2 = 3'd2; press = 1'b1; press2 = 1'b1;
    wait_valid(40);
    check(key_valid && key_code == 6'd26, "R8", key_code, 26);
    release_and_resume();
    pr = 3'd6; pc = 3'd0; pc2 = 3'd7; press = 1'b1; press2 = 1'b1;
    wait_valid(40);
    check(key_valid && key_code == 6'd48, "R8", key_code, 48);
    release_and_resume();

    finish_run();
  end
endmodule